// File: doc/BRIEF.md
# Mixed-Radix Oscillator Tuning Code Stepper

This block keeps the tuning word of a digitally controlled oscillator and moves it one least-significant step at a time for a loop controller. The word has five fields. A 6-bit coarse field sits on top. Below it are four fine fields of decreasing weight, 3, 5, 2 and 3 bits wide. Each field counts through all of its stages. When it passes its top it returns to zero and advances the next heavier field. When it passes zero it returns to its top and takes one from the next heavier field.

Every field is also expanded into a thermometer switch vector that turns on a matching number of delay or capacitor cells. The coarse field's vector works as a chain enable: it keeps every delay stage above the selected one switched off, so those stages do not toggle. A controller can also write a full packed word directly, for example to restore a known starting point before tracking resumes.

Top module: `dco_code_stepper`

## Requirements
- R1: While the asynchronous active-low reset is asserted, every field value and every thermometer or enable bit is zero.
- R2: An increment strobe alone adds one to fine field 4. A field at its top value returns to zero and carries one into the next heavier field. The carry order is fine 4, fine 3, fine 2, fine 1, then coarse. The new value appears at the outputs one clock after the strobe is sampled.
- R3: A decrement strobe alone subtracts one from fine field 4. A field at zero goes to its top value and borrows one from the next heavier field, in the same order as R2.
- R4: An increment when every field is at its top value leaves the word unchanged.
- R5: A decrement when every field is zero leaves the word unchanged.
- R6: Increment and decrement asserted together leave the word unchanged.
- R7: A load strobe replaces the word with the 19-bit load value, one clock later, and takes priority over both step strobes. The load layout is: coarse in bits 18:13, fine 1 in bits 12:10, fine 2 in bits 9:5, fine 3 in bits 4:3, fine 4 in bits 2:0.
- R8: Each fine thermometer vector has bit i set exactly when its field value is greater than i. The vector widths are 7 for fine 1, 31 for fine 2, 3 for fine 3 and 7 for fine 4. The vectors are registered and change in the same cycle as the field values.
- R9: The 63-bit coarse enable vector has bit i set exactly when the coarse value is greater than i. It is registered alongside the fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_i | input | 1 | Step the word up by one |
| dec_i | input | 1 | Step the word down by one |
| load_i | input | 1 | Write load_word_i into the word |
| load_word_i | input | 19 | Packed word to load |
| coarse_o | output | 6 | Coarse field value |
| fine1_o | output | 3 | Fine field 1 value |
| fine2_o | output | 5 | Fine field 2 value |
| fine3_o | output | 2 | Fine field 3 value |
| fine4_o | output | 3 | Fine field 4 value |
| coarse_en_o | output | 63 | Coarse delay chain enable thermometer |
| fine1_th_o | output | 7 | Fine 1 switch thermometer |
| fine2_th_o | output | 31 | Fine 2 switch thermometer |
| fine3_th_o | output | 3 | Fine 3 switch thermometer |
| fine4_th_o | output | 7 | Fine 4 switch thermometer |

## Verification
A broken carry or borrow link shows up on the very next clock. The heavier field fails to move, or moves when it should not, at the moment the lighter field wraps. For this reason the stimulus loads words that sit just below and just above each field boundary, and then steps once. A thermometer decoded from the wrong value, or registered at the wrong time, differs from the field value in that same cycle. Every clock compares all outputs against a behavioural model, so an error is caught the cycle it first appears. Saturation faults show up only at the two extremes, and those extremes are driven on purpose.

// File: rtl/dco_step_pkg.sv
package dco_step_pkg;
  localparam int NFIELD = 5;

  // field widths, index 0 is the lightest (fine 4), index 4 the coarse field
  function automatic int fld_w(input int k);
    case (k)
      0: return 3;
      1: return 2;
      2: return 5;
      3: return 3;
      default: return 6;
    endcase
  endfunction

  function automatic int fld_lsb(input int k);
    int s = 0;
    for (int j = 0; j < k; j++) s += fld_w(j);
    return s;
  endfunction

  function automatic int th_w(input int k);
    return (1 << fld_w(k)) - 1;
  endfunction

  function automatic int th_lsb(input int k);
    int s = 0;
    for (int j = 0; j < k; j++) s += th_w(j);
    return s;
  endfunction

  localparam int WORD_W  = fld_lsb(NFIELD);
  localparam int THERM_W = th_lsb(NFIELD);
endpackage

// File: rtl/dco_field_step.sv
module dco_field_step #(
  parameter int W = 3
) (
  input  logic [W-1:0] val_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic [W-1:0] val_o,
  output logic         up_o,
  output logic         dn_o
);
  localparam logic [W-1:0] TOP = '1;

  always_comb begin
    val_o = val_i;
    up_o  = 1'b0;
    dn_o  = 1'b0;
    if (up_i) begin
      if (val_i == TOP) begin
        val_o = '0;
        up_o  = 1'b1;
      end else begin
        val_o = val_i + W'(1);
      end
    end else if (dn_i) begin
      if (val_i == '0) begin
        val_o = TOP;
        dn_o  = 1'b1;
      end else begin
        val_o = val_i - W'(1);
      end
    end
  end
endmodule

// File: rtl/dco_therm_dec.sv
module dco_therm_dec #(
  parameter int W = 3,
  parameter int N = (1 << W) - 1
) (
  input  logic [W-1:0] code_i,
  output logic [N-1:0] therm_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign therm_o[i] = (code_i > W'(i));
  end
endmodule

// File: rtl/dco_code_stepper.sv
module dco_code_stepper
  import dco_step_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inc_i,
  input  logic        dec_i,
  input  logic        load_i,
  input  logic [18:0] load_word_i,
  output logic [5:0]  coarse_o,
  output logic [2:0]  fine1_o,
  output logic [4:0]  fine2_o,
  output logic [1:0]  fine3_o,
  output logic [2:0]  fine4_o,
  output logic [62:0] coarse_en_o,
  output logic [6:0]  fine1_th_o,
  output logic [30:0] fine2_th_o,
  output logic [2:0]  fine3_th_o,
  output logic [6:0]  fine4_th_o
);
  logic [WORD_W-1:0]  word_q, word_d, word_step;
  logic [THERM_W-1:0] therm_q, therm_d;
  logic [NFIELD:0]    up_c, dn_c;
  logic               step_ok, word_en;

  // a lone strobe enters at the lightest field
  assign up_c[0] = inc_i & ~dec_i;
  assign dn_c[0] = dec_i & ~inc_i;

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    localparam int LO  = fld_lsb(g);
    localparam int FW  = fld_w(g);
    localparam int TLO = th_lsb(g);
    localparam int TW  = th_w(g);

    dco_field_step #(.W(FW)) u_step (
      .val_i (word_q[LO +: FW]),
      .up_i  (up_c[g]),
      .dn_i  (dn_c[g]),
      .val_o (word_step[LO +: FW]),
      .up_o  (up_c[g+1]),
      .dn_o  (dn_c[g+1])
    );

    dco_therm_dec #(.W(FW), .N(TW)) u_dec (
      .code_i  (word_d[LO +: FW]),
      .therm_o (therm_d[TLO +: TW])
    );
  end

  // carry or borrow out of the coarse field means the word is at an end
  assign step_ok = (up_c[0] | dn_c[0]) & ~up_c[NFIELD] & ~dn_c[NFIELD];
  assign word_en = load_i | step_ok;

  always_comb begin
    word_d = word_q;
    if (load_i)       word_d = load_word_i;
    else if (step_ok) word_d = word_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      therm_q <= '0;
    end else if (word_en) begin
      word_q  <= word_d;
      therm_q <= therm_d;
    end
  end

  assign fine4_o     = word_q[fld_lsb(0) +: fld_w(0)];
  assign fine3_o     = word_q[fld_lsb(1) +: fld_w(1)];
  assign fine2_o     = word_q[fld_lsb(2) +: fld_w(2)];
  assign fine1_o     = word_q[fld_lsb(3) +: fld_w(3)];
  assign coarse_o    = word_q[fld_lsb(4) +: fld_w(4)];
  assign fine4_th_o  = therm_q[th_lsb(0) +: th_w(0)];
  assign fine3_th_o  = therm_q[th_lsb(1) +: th_w(1)];
  assign fine2_th_o  = therm_q[th_lsb(2) +: th_w(2)];
  assign fine1_th_o  = therm_q[th_lsb(3) +: th_w(3)];
  assign coarse_en_o = therm_q[th_lsb(4) +: th_w(4)];
endmodule

// File: rtl/dco_code_stepper_chk.sv
module dco_code_stepper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        inc_i,
  input logic        dec_i,
  input logic        load_i,
  input logic [18:0] load_word_i,
  input logic [5:0]  coarse_o,
  input logic [2:0]  fine1_o,
  input logic [4:0]  fine2_o,
  input logic [1:0]  fine3_o,
  input logic [2:0]  fine4_o,
  input logic [62:0] coarse_en_o,
  input logic [6:0]  fine1_th_o,
  input logic [30:0] fine2_th_o,
  input logic [2:0]  fine3_th_o,
  input logic [6:0]  fine4_th_o
);
  logic [18:0] w;
  assign w = {coarse_o, fine1_o, fine2_o, fine3_o, fine4_o};

  a_r2_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !dec_i && !load_i && w != '1) |=> (w == $past(w) + 19'd1));

  a_r3_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i && !load_i && w != '0) |=> (w == $past(w) - 19'd1));

  a_r4_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !dec_i && !load_i && w == '1) |=> $stable(w));

  a_r5_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i && !load_i && w == '0) |=> $stable(w));

  a_r6_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && dec_i && !load_i) |=> $stable(w));

  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (w == $past(load_word_i)));

  a_r8_fine_therm: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(fine1_th_o) == int'(fine1_o)) && ((fine1_th_o & (fine1_th_o + 7'd1)) == '0) &&
    ($countones(fine2_th_o) == int'(fine2_o)) && ((fine2_th_o & (fine2_th_o + 31'd1)) == '0) &&
    ($countones(fine3_th_o) == int'(fine3_o)) && ((fine3_th_o & (fine3_th_o + 3'd1)) == '0) &&
    ($countones(fine4_th_o) == int'(fine4_o)) && ((fine4_th_o & (fine4_th_o + 7'd1)) == '0));

  a_r9_coarse_en: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(coarse_en_o) == int'(coarse_o)) &&
    ((coarse_en_o & (coarse_en_o + 63'd1)) == '0));
endmodule

bind dco_code_stepper dco_code_stepper_chk u_chk (.*);

// File: tb/dco_code_stepper_bench.sv
module dco_code_stepper_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        inc_i, dec_i, load_i;
  logic [18:0] load_word_i;
  logic [5:0]  coarse_o;
  logic [2:0]  fine1_o, fine4_o;
  logic [4:0]  fine2_o;
  logic [1:0]  fine3_o;
  logic [62:0] coarse_en_o;
  logic [6:0]  fine1_th_o, fine4_th_o;
  logic [30:0] fine2_th_o;
  logic [2:0]  fine3_th_o;

  int          errors = 0;
  int          checks = 0;
  logic [18:0] mdl;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dco_code_stepper u_dco_code_stepper (.*);

  function automatic logic [62:0] therm(input int v);
    return (63'(1) << v) - 63'(1);
  endfunction

  task automatic chk(input string tag, input bit ok, input logic [62:0] act, input logic [62:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [18:0] w;
    w = {coarse_o, fine1_o, fine2_o, fine3_o, fine4_o};
    chk(tag, w == mdl, 63'(w), 63'(mdl));
    chk("R8 f1", fine1_th_o == therm(int'(mdl[12:10]))
        , 63'(fine1_th_o), therm(int'(mdl[12:10])));
    chk("R8 f2", fine2_th_o == 31'(therm(int'(mdl[9:5])))
        , 63'(fine2_th_o), therm(int'(mdl[9:5])));
    chk("R8 f3", fine3_th_o == 3'(therm(int'(mdl[4:3])))
        , 63'(fine3_th_o), therm(int'(mdl[4:3])));
    chk("R8 f4", fine4_th_o == 7'(therm(int'(mdl[2:0])))
        , 63'(fine4_th_o), therm(int'(mdl[2:0])));
    chk("R9", coarse_en_o == therm(int'(mdl[18:13])), coarse_en_o, therm(int'(mdl[18:13])));
  endtask

  task automatic drive(input bit inc, input bit dec, input bit ld, input logic [18:0] lw, input string tag);
    inc_i = inc; dec_i = dec; load_i = ld; load_word_i = lw;
    @(posedge clk);
    if (ld) mdl = lw;
    else if (inc && !dec) begin if (mdl != '1) mdl = mdl + 19'd1; end
    else if (dec && !inc) begin if (mdl != '0) mdl = mdl - 19'd1; end
    @(negedge clk);
    inc_i = 1'b0; dec_i = 1'b0; load_i = 1'b0;
    compare(tag);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; inc_i = 1'b0; dec_i = 1'b0; load_i = 1'b0; load_word_i = '0;
    mdl = '0;
    repeat (2) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;

    for (int i = 0; i < 20; i++) drive(1, 0, 0, '0, "R2 count up");
    drive(0, 0, 1, 19'h00007, "R7 load");
    drive(1, 0, 0, '0, "R2 f4 into f3");
    drive(0, 0, 1, 19'h0001F, "R7 load");
    drive(1, 0, 0, '0, "R2 f3 into f2");
    drive(0, 0, 1, 19'h003FF, "R7 load");
    drive(1, 0, 0, '0, "R2 f2 into f1");
    drive(0, 0, 1, 19'h01FFF, "R7 load");
    drive(1, 0, 0, '0, "R2 f1 into coarse");

    drive(0, 0, 1, 19'h02000, "R7 load");
    drive(0, 1, 0, '0, "R3 borrow from coarse");
    drive(0, 0, 1, 19'h00008, "R7 load");
    drive(0, 1, 0, '0, "R3 borrow from f3");
    for (int i = 0; i < 10; i++) drive(0, 1, 0, '0, "R3 count down");

    drive(0, 0, 1, 19'h00000, "R7 load");
    drive(0, 1, 0, '0, "R5 floor");
    drive(0, 1, 0, '0, "R5 floor");
    drive(0, 0, 1, 19'h7FFFF, "R7 load");
    drive(1, 0, 0, '0, "R4 ceiling");
    drive(1, 0, 0, '0, "R4 ceiling");
    drive(0, 1, 0, '0, "R3 from top");

    drive(0, 0, 1, 19'h12345, "R7 load");
    drive(1, 1, 0, '0, "R6 both");
    drive(1, 1, 0, '0, "R6 both");
    drive(1, 0, 1, 19'h0ABCD, "R7 load beats inc");
    drive(0, 1, 1, 19'h55555, "R7 load beats dec");

    for (int i = 0; i < 200; i++) begin
      logic [18:0] r;
      r = 19'($urandom);
      case (i % 4)
        0: drive(0, 0, 1, r, "R7 random load");
        1: drive(1, 0, 0, '0, "R2 random inc");
        2: drive(0, 1, 0, '0, "R3 random dec");
        default: drive(1, 1, 0, '0, "R6 random both");
      endcase
    end
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1..: actual=running expected=finished");
      summary();
    end
  end
endmodule